// File: doc/BRIEF.md
# Indirect Memory Window with Auto-Increment

This block gives a host, through a small set of 32-bit registers, indirect access to memory and registers inside a device. A memory access starts with an address loaded into a pointer register. A read of the read-data register, or a write of the write-data register, then runs one word transfer on the internal bus. The matching pointer steps forward by one dword after each transfer, so a burst of consecutive words needs the address set up only once. The read pointer and the write pointer are separate, so a read burst and a write burst can be interleaved without reloading either pointer.

A second path reaches internal peripheral registers. Its address word holds a register offset in bits 15:0 and a transfer size, written as byte count minus one, in bits 25:24. The path turns the size into byte enables that start at byte lane 0. This path never steps its address. The host port stalls a data-register access, with its ready signal held low, until the internal bus acknowledges the transfer.

Top module: `indirect_mem_window`

## Requirements
- R1: The register index `host_reg` selects one of eight registers: 0 memory read pointer, 1 memory write pointer, 2 memory read data, 3 memory write data, 4 peripheral read address word, 5 peripheral write address word, 6 peripheral read data, 7 peripheral write data. Indices 0, 1, 4 and 5 read back the full 32-bit value last written to them.
- R2: After reset, both pointers and both peripheral address words are zero, and `bus_req` and `host_ready` are low.
- R3: A host read of index 2 runs one bus read with `bus_space`=0, `bus_addr` equal to the read pointer and `bus_be`=4'hF, and returns the word from the bus.
- R4: Each completed memory read adds 4 to the read pointer and leaves the write pointer unchanged.
- R5: A host write of index 3 runs one bus write with `bus_space`=0, `bus_addr` equal to the write pointer, `bus_be`=4'hF and the host data. After it, the write pointer has grown by 4 and the read pointer is unchanged.
- R6: Both pointers wrap modulo 2^32, so a step from 32'hFFFF_FFFC gives 0.
- R7: A peripheral transfer (index 6 read or index 7 write) drives `bus_space`=1 and `bus_addr` = {16'b0, word[15:0]}. Bit i of `bus_be` is set exactly when i <= word[25:24]. The other bits of the address word do not affect the transfer, and the address word never changes by itself.
- R8: On a peripheral read, byte lanes that are not enabled are returned to the host as zero.
- R9: An access to a pointer or address-word register completes with `host_ready` high for one cycle, one clock after it is accepted. A data access keeps `host_ready` low while `bus_req` is high, and raises it for one cycle one clock after the edge at which `bus_ack` is seen. With the acknowledge arriving L cycles after the request starts, that edge is L+2 clocks after acceptance.
- R10: A host write to index 2 or 6, or a host read of index 3 or 7, runs no bus transfer and changes no register. Such an access completes like a pointer access, and a read of this kind returns zero.
- R11: Once `bus_req` rises, it stays high, with `bus_addr`, `bus_be`, `bus_we` and `bus_wdata` unchanged, until `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Host access request, held until `host_ready` |
| host_write | input | 1 | 1 = write, 0 = read |
| host_reg | input | 3 | Register index (see R1) |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | One-cycle completion strobe |
| host_rdata | output | 32 | Read data, valid while `host_ready` is high |
| bus_req | output | 1 | Internal bus transfer request |
| bus_we | output | 1 | Internal bus write |
| bus_space | output | 1 | 0 = memory, 1 = peripheral registers |
| bus_addr | output | 32 | Internal byte address or register offset |
| bus_be | output | 4 | Byte enables |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Transfer done; read data valid |
| bus_rdata | input | 32 | Internal bus read data |

## Verification
The bench's bus model acknowledges a transfer a set number L of cycles after the request starts. A data access should then complete L+3 falling edges after the falling edge at which the access was driven. A pointer, address-word or ignored access should complete on the very next falling edge. The bench drives each access on a falling edge and counts falling edges until `host_ready` is seen, and it checks that count against the expected figure for every vector. It reads the data and the logged bus transfer only at that completion edge, which is after the acknowledge edge, so the model's log has already been updated.

// File: rtl/imw_pkg.sv
package imw_pkg;

   localparam int unsigned REG_SEL_W = 3;

   typedef enum logic [REG_SEL_W-1:0] {
      REG_MEM_RPTR   = 3'd0,
      REG_MEM_WPTR   = 3'd1,
      REG_MEM_RDAT   = 3'd2,
      REG_MEM_WDAT   = 3'd3,
      REG_PRPH_RWORD = 3'd4,
      REG_PRPH_WWORD = 3'd5,
      REG_PRPH_RDAT  = 3'd6,
      REG_PRPH_WDAT  = 3'd7
   } win_reg_e;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_BUSY = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/imw_ptr.sv
// Auto-stepping address pointer: load has priority over advance.
module imw_ptr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              advance,
   output logic [ADDR_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= load_val;
      end else if (advance) begin
         ptr <= ptr + STEP_V;
      end
   end
endmodule

// File: rtl/imw_prph_map.sv
// Maps a peripheral offset and size code to a bus address and low-aligned byte enables.
module imw_prph_map #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFFS_W = 16,
   parameter int unsigned BE_W   = 4,
   parameter int unsigned CNT_W  = 2
) (
   input  logic [OFFS_W-1:0] offs,
   input  logic [CNT_W-1:0]  cnt,
   output logic [ADDR_W-1:0] addr,
   output logic [BE_W-1:0]   be
);
   assign addr = ADDR_W'(offs);

   for (genvar i = 0; i < BE_W; i++) begin : g_lane
      if (i == 0) begin : g_first
         assign be[i] = 1'b1;
      end else begin : g_rest
         localparam logic [CNT_W-1:0] LANE = CNT_W'(i);
         assign be[i] = (LANE <= cnt);
      end
   end
endmodule

// File: rtl/imw_seq.sv
// Host/bus sequencer: accepts one host access, runs at most one bus transfer, strobes ready.
module imw_seq
   import imw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              launch,
   input  logic              l_we,
   input  logic              l_space,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [BE_W-1:0]   l_be,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic [DATA_W-1:0] imm_rdata,
   output logic              idle,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_space,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BE_W-1:0]   bus_be,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              cpl,
   output logic              cpl_we,
   output logic              cpl_space
);
   seq_state_e        state_q;
   logic              we_q;
   logic              space_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BE_W-1:0]   be_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] lane_mask;

   for (genvar b = 0; b < BE_W; b++) begin : g_mask
      assign lane_mask[b*8 +: 8] = {8{be_q[b]}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         we_q    <= 1'b0;
         space_q <= 1'b0;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  if (launch) begin
                     we_q    <= l_we;
                     space_q <= l_space;
                     addr_q  <= l_addr;
                     be_q    <= l_be;
                     wdata_q <= l_wdata;
                     state_q <= SEQ_BUSY;
                  end else begin
                     rdata_q <= imm_rdata;
                     state_q <= SEQ_DONE;
                  end
               end
            end
            SEQ_BUSY: begin
               if (bus_ack) begin
                  rdata_q <= we_q ? '0 : (bus_rdata & lane_mask);
                  state_q <= SEQ_DONE;
               end
            end
            SEQ_DONE: state_q <= SEQ_IDLE;
            default:  state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign idle       = (state_q == SEQ_IDLE);
   assign host_ready = (state_q == SEQ_DONE);
   assign host_rdata = rdata_q;
   assign bus_req    = (state_q == SEQ_BUSY);
   assign bus_we     = we_q;
   assign bus_space  = space_q;
   assign bus_addr   = addr_q;
   assign bus_be     = be_q;
   assign bus_wdata  = wdata_q;
   assign cpl        = (state_q == SEQ_BUSY) && bus_ack;
   assign cpl_we     = we_q;
   assign cpl_space  = space_q;
endmodule

// File: rtl/indirect_mem_window.sv
module indirect_mem_window
   import imw_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned OFFS_W     = 16,
   parameter int unsigned CNT_LSB    = 24,
   parameter int unsigned STEP_BYTES = 4,
   parameter bit          HAS_PERIPH = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_valid,
   input  logic                host_write,
   input  logic [2:0]          host_reg,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic                host_ready,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                bus_req,
   output logic                bus_we,
   output logic                bus_space,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [DATA_W/8-1:0] bus_be,
   output logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_ack,
   input  logic [DATA_W-1:0]   bus_rdata
);
   localparam int unsigned BE_W  = DATA_W / 8;
   localparam int unsigned CNT_W = (BE_W > 1) ? $clog2(BE_W) : 1;

   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("DATA_W must be a whole number of bytes");
   end
   if (ADDR_W != DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must equal DATA_W so pointers read back whole");
   end
   if (OFFS_W > CNT_LSB || CNT_LSB + CNT_W > DATA_W) begin : g_bad_fields
      $error("peripheral offset and size fields must fit the word without overlap");
   end
   if (STEP_BYTES != BE_W) begin : g_bad_step
      $error("STEP_BYTES must equal one data word");
   end

   win_reg_e          sel;
   logic              idle;
   logic              start;
   logic              wr_ev;
   logic              cpl;
   logic              cpl_we;
   logic              cpl_space;
   logic [ADDR_W-1:0] mem_rptr;
   logic [ADDR_W-1:0] mem_wptr;

   logic              prph_ok;
   logic [DATA_W-1:0] prph_rword;
   logic [DATA_W-1:0] prph_wword;
   logic [ADDR_W-1:0] prph_raddr;
   logic [ADDR_W-1:0] prph_waddr;
   logic [BE_W-1:0]   prph_rbe;
   logic [BE_W-1:0]   prph_wbe;

   logic              launch;
   logic              l_we;
   logic              l_space;
   logic [ADDR_W-1:0] l_addr;
   logic [BE_W-1:0]   l_be;
   logic [DATA_W-1:0] imm_rdata;

   assign sel   = win_reg_e'(host_reg);
   assign start = host_valid && idle;
   assign wr_ev = start && host_write;

   imw_ptr #(.ADDR_W(ADDR_W), .STEP(STEP_BYTES)) u_rptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_ev && (sel == REG_MEM_RPTR)),
      .load_val (host_wdata[ADDR_W-1:0]),
      .advance  (cpl && !cpl_we && !cpl_space),
      .ptr      (mem_rptr)
   );

   imw_ptr #(.ADDR_W(ADDR_W), .STEP(STEP_BYTES)) u_wptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_ev && (sel == REG_MEM_WPTR)),
      .load_val (host_wdata[ADDR_W-1:0]),
      .advance  (cpl && cpl_we && !cpl_space),
      .ptr      (mem_wptr)
   );

   if (HAS_PERIPH) begin : g_prph
      logic [DATA_W-1:0] rword_q;
      logic [DATA_W-1:0] wword_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rword_q <= '0;
            wword_q <= '0;
         end else begin
            if (wr_ev && (sel == REG_PRPH_RWORD)) rword_q <= host_wdata;
            if (wr_ev && (sel == REG_PRPH_WWORD)) wword_q <= host_wdata;
         end
      end

      imw_prph_map #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .BE_W(BE_W), .CNT_W(CNT_W)) u_rmap (
         .offs (rword_q[OFFS_W-1:0]),
         .cnt  (rword_q[CNT_LSB +: CNT_W]),
         .addr (prph_raddr),
         .be   (prph_rbe)
      );

      imw_prph_map #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .BE_W(BE_W), .CNT_W(CNT_W)) u_wmap (
         .offs (wword_q[OFFS_W-1:0]),
         .cnt  (wword_q[CNT_LSB +: CNT_W]),
         .addr (prph_waddr),
         .be   (prph_wbe)
      );

      assign prph_ok    = 1'b1;
      assign prph_rword = rword_q;
      assign prph_wword = wword_q;
   end else begin : g_no_prph
      assign prph_ok    = 1'b0;
      assign prph_rword = '0;
      assign prph_wword = '0;
      assign prph_raddr = '0;
      assign prph_waddr = '0;
      assign prph_rbe   = '0;
      assign prph_wbe   = '0;
   end

   // Which accesses become bus transfers, and with what attributes.
   always_comb begin
      launch  = 1'b0;
      l_we    = 1'b0;
      l_space = 1'b0;
      l_addr  = mem_rptr;
      l_be    = '1;
      unique case (sel)
         REG_MEM_RDAT: begin
            launch = !host_write;
         end
         REG_MEM_WDAT: begin
            launch = host_write;
            l_we   = 1'b1;
            l_addr = mem_wptr;
         end
         REG_PRPH_RDAT: begin
            launch  = !host_write && prph_ok;
            l_space = 1'b1;
            l_addr  = prph_raddr;
            l_be    = prph_rbe;
         end
         REG_PRPH_WDAT: begin
            launch  = host_write && prph_ok;
            l_we    = 1'b1;
            l_space = 1'b1;
            l_addr  = prph_waddr;
            l_be    = prph_wbe;
         end
         default: ;
      endcase
   end

   // Read-back value of the register-only accesses.
   always_comb begin
      imm_rdata = '0;
      if (!host_write) begin
         unique case (sel)
            REG_MEM_RPTR:   imm_rdata = DATA_W'(mem_rptr);
            REG_MEM_WPTR:   imm_rdata = DATA_W'(mem_wptr);
            REG_PRPH_RWORD: imm_rdata = prph_rword;
            REG_PRPH_WWORD: imm_rdata = prph_wword;
            default:        imm_rdata = '0;
         endcase
      end
   end

   imw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .launch     (launch),
      .l_we       (l_we),
      .l_space    (l_space),
      .l_addr     (l_addr),
      .l_be       (l_be),
      .l_wdata    (host_wdata),
      .imm_rdata  (imm_rdata),
      .idle       (idle),
      .host_ready (host_ready),
      .host_rdata (host_rdata),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_space  (bus_space),
      .bus_addr   (bus_addr),
      .bus_be     (bus_be),
      .bus_wdata  (bus_wdata),
      .bus_ack    (bus_ack),
      .bus_rdata  (bus_rdata),
      .cpl        (cpl),
      .cpl_we     (cpl_we),
      .cpl_space  (cpl_space)
   );
endmodule

// File: rtl/imw_chk.sv
module imw_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned OFFS_W     = 16,
   parameter int unsigned STEP_BYTES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                host_ready,
   input logic                bus_req,
   input logic                bus_ack,
   input logic                bus_we,
   input logic                bus_space,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W/8-1:0] bus_be,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [ADDR_W-1:0]   rd_ptr,
   input logic [ADDR_W-1:0]   wr_ptr
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_BYTES);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req);                                   // R11
   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_be)
                              && $stable(bus_we) && $stable(bus_wdata));  // R11
   AST_NO_READY_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !host_ready);                                           // R9
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |=> !host_ready);                                        // R9
   AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && !bus_we && !bus_space
      |=> rd_ptr == $past(rd_ptr) + STEP_V && $stable(wr_ptr));           // R4
   AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && bus_we && !bus_space
      |=> wr_ptr == $past(wr_ptr) + STEP_V && $stable(rd_ptr));           // R5
   AST_MEM_FULL_BE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_space |-> &bus_be);                                 // R3
   AST_PRPH_BE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_space |-> bus_be[0] && ((bus_be & (bus_be + 1'b1)) == '0)); // R7
   AST_PRPH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_space |-> (bus_addr >> OFFS_W) == '0);               // R7
   AST_PRPH_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && bus_space |=> $stable(rd_ptr) && $stable(wr_ptr)); // R7
endmodule

bind indirect_mem_window imw_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .OFFS_W     (OFFS_W),
   .STEP_BYTES (STEP_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_ready (host_ready),
   .bus_req    (bus_req),
   .bus_ack    (bus_ack),
   .bus_we     (bus_we),
   .bus_space  (bus_space),
   .bus_addr   (bus_addr),
   .bus_be     (bus_be),
   .bus_wdata  (bus_wdata),
   .rd_ptr     (mem_rptr),
   .wr_ptr     (mem_wptr)
);

// File: tb/tb_indirect_mem_window.sv
`timescale 1ns/1ps
module tb_indirect_mem_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0;
   logic        host_write = 1'b0;
   logic [2:0]  host_reg = 3'd0;
   logic [31:0] host_wdata = 32'h0;
   logic        host_ready;
   logic [31:0] host_rdata;
   logic        bus_req;
   logic        bus_we;
   logic        bus_space;
   logic [31:0] bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = 32'h0;

   always #10 clk = ~clk;

   indirect_mem_window dut (
      .clk(clk), .rst_n(rst_n),
      .host_valid(host_valid), .host_write(host_write), .host_reg(host_reg),
      .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
      .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit finished = 1'b0;

   // ---------------- bus model ----------------
   logic [31:0] mem_m  [64];
   logic [31:0] prph_m [16];
   int          cur_lat = 0;
   int          wcnt = 0;
   int          txn_cnt = 0;
   int          stab_err = 0;
   logic [31:0] first_addr = 32'h0;
   logic [31:0] last_addr = 32'h0;
   logic [3:0]  last_be = 4'h0;
   logic        last_we = 1'b0;
   logic        last_space = 1'b0;
   logic [31:0] last_wdata = 32'h0;

   always @(posedge clk) begin
      if (!rst_n) begin
         bus_ack <= 1'b0;
         wcnt    <= 0;
         for (int i = 0; i < 64; i++) mem_m[i]  <= 32'hA500_0000 | 32'(i);
         for (int i = 0; i < 16; i++) prph_m[i] <= 32'h8877_6650 + 32'(i);
      end else if (bus_req && !bus_ack) begin
         if (wcnt == 0) first_addr <= bus_addr;
         else if (bus_addr !== first_addr) stab_err <= stab_err + 1;
         if (wcnt >= cur_lat) begin
            bus_ack    <= 1'b1;
            wcnt       <= 0;
            txn_cnt    <= txn_cnt + 1;
            last_addr  <= bus_addr;
            last_be    <= bus_be;
            last_we    <= bus_we;
            last_space <= bus_space;
            last_wdata <= bus_wdata;
            if (bus_we) begin
               for (int b = 0; b < 4; b++) begin
                  if (bus_be[b]) begin
                     if (bus_space) prph_m[bus_addr[3:0]][b*8 +: 8] <= bus_wdata[b*8 +: 8];
                     else           mem_m[bus_addr[7:2]][b*8 +: 8]  <= bus_wdata[b*8 +: 8];
                  end
               end
            end
            bus_rdata <= bus_space ? prph_m[bus_addr[3:0]] : mem_m[bus_addr[7:2]];
         end else begin
            wcnt <= wcnt + 1;
         end
      end else begin
         bus_ack <= 1'b0;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input int rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic run_op(input logic wr, input logic [2:0] rg, input logic [31:0] wd,
                         input int lat, output logic [31:0] rd, output int n);
      @(negedge clk);
      cur_lat    = lat;
      host_valid = 1'b1;
      host_write = wr;
      host_reg   = rg;
      host_wdata = wd;
      #1;
      n = 0;
      while (!host_ready && n < 100) begin
         @(negedge clk);
         #1;
         n++;
      end
      rd = host_rdata;
      host_valid = 1'b0;
   endtask

   // ---------------- vector table ----------------
   typedef struct packed {
      logic        wr;
      logic [2:0]  rg;
      logic [31:0] wd;
      logic [3:0]  lat;
      logic [31:0] exp_rd;
      logic        chk_rd;
      logic        bus;
      logic [31:0] baddr;
      logic [3:0]  be;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 39;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 3'd0, 32'h0000_0010, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b0, 3'd0, 32'h0,         4'd0, 32'h0000_0010, 1'b1, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b0, 3'd2, 32'h0,         4'd0, 32'hA500_0004, 1'b1, 1'b1, 32'h0000_0010, 4'hF, 8'd3},  // R3
      '{1'b0, 3'd2, 32'h0,         4'd2, 32'hA500_0005, 1'b1, 1'b1, 32'h0000_0014, 4'hF, 8'd4},  // R4
      '{1'b0, 3'd0, 32'h0,         4'd0, 32'h0000_0018, 1'b1, 1'b0, 32'h0,         4'h0, 8'd4},  // R4
      '{1'b1, 3'd1, 32'h0000_0020, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b1, 3'd3, 32'hDEAD_BEEF, 4'd1, 32'h0,         1'b0, 1'b1, 32'h0000_0020, 4'hF, 8'd5},  // R5
      '{1'b1, 3'd3, 32'h1234_5678, 4'd0, 32'h0,         1'b0, 1'b1, 32'h0000_0024, 4'hF, 8'd5},  // R5
      '{1'b0, 3'd1, 32'h0,         4'd0, 32'h0000_0028, 1'b1, 1'b0, 32'h0,         4'h0, 8'd5},  // R5
      '{1'b0, 3'd0, 32'h0,         4'd0, 32'h0000_0018, 1'b1, 1'b0, 32'h0,         4'h0, 8'd5},  // R5
      '{1'b1, 3'd0, 32'h0000_0020, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b0, 3'd2, 32'h0,         4'd3, 32'hDEAD_BEEF, 1'b1, 1'b1, 32'h0000_0020, 4'hF, 8'd9},  // R9
      '{1'b0, 3'd2, 32'h0,         4'd0, 32'h1234_5678, 1'b1, 1'b1, 32'h0000_0024, 4'hF, 8'd3},  // R3
      '{1'b1, 3'd4, 32'hFDAB_0008, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b0, 3'd6, 32'h0,         4'd1, 32'h0000_6658, 1'b1, 1'b1, 32'h0000_0008, 4'h3, 8'd8},  // R8
      '{1'b0, 3'd6, 32'h0,         4'd0, 32'h0000_6658, 1'b1, 1'b1, 32'h0000_0008, 4'h3, 8'd7},  // R7
      '{1'b0, 3'd4, 32'h0,         4'd0, 32'hFDAB_0008, 1'b1, 1'b0, 32'h0,         4'h0, 8'd7},  // R7
      '{1'b1, 3'd5, 32'h0300_0004, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b1, 3'd7, 32'hCAFE_F00D, 4'd0, 32'h0,         1'b0, 1'b1, 32'h0000_0004, 4'hF, 8'd7},  // R7
      '{1'b1, 3'd5, 32'h0000_0005, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b1, 3'd7, 32'h0000_00AA, 4'd2, 32'h0,         1'b0, 1'b1, 32'h0000_0005, 4'h1, 8'd7},  // R7
      '{1'b1, 3'd4, 32'h0300_0004, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b0, 3'd6, 32'h0,         4'd0, 32'hCAFE_F00D, 1'b1, 1'b1, 32'h0000_0004, 4'hF, 8'd7},  // R7
      '{1'b1, 3'd4, 32'h0200_0005, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b0, 3'd6, 32'h0,         4'd0, 32'h0077_66AA, 1'b1, 1'b1, 32'h0000_0005, 4'h7, 8'd8},  // R8
      '{1'b1, 3'd2, 32'h0000_0055, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd10}, // R10
      '{1'b0, 3'd3, 32'h0,         4'd0, 32'h0,         1'b1, 1'b0, 32'h0,         4'h0, 8'd10}, // R10
      '{1'b1, 3'd6, 32'h0000_0066, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd10}, // R10
      '{1'b0, 3'd7, 32'h0,         4'd0, 32'h0,         1'b1, 1'b0, 32'h0,         4'h0, 8'd10}, // R10
      '{1'b0, 3'd0, 32'h0,         4'd0, 32'h0000_0028, 1'b1, 1'b0, 32'h0,         4'h0, 8'd10}, // R10
      '{1'b0, 3'd1, 32'h0,         4'd0, 32'h0000_0028, 1'b1, 1'b0, 32'h0,         4'h0, 8'd10}, // R10
      '{1'b1, 3'd0, 32'hFFFF_FFFC, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b0, 3'd2, 32'h0,         4'd0, 32'hA500_003F, 1'b1, 1'b1, 32'hFFFF_FFFC, 4'hF, 8'd6},  // R6
      '{1'b0, 3'd0, 32'h0,         4'd0, 32'h0,         1'b1, 1'b0, 32'h0,         4'h0, 8'd6},  // R6
      '{1'b1, 3'd1, 32'hFFFF_FFFC, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b1, 3'd3, 32'h0000_0077, 4'd0, 32'h0,         1'b0, 1'b1, 32'hFFFF_FFFC, 4'hF, 8'd6},  // R6
      '{1'b0, 3'd1, 32'h0,         4'd0, 32'h0,         1'b1, 1'b0, 32'h0,         4'h0, 8'd6},  // R6
      '{1'b1, 3'd0, 32'hFFFF_FFFC, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         4'h0, 8'd1},  // R1
      '{1'b0, 3'd2, 32'h0,         4'd0, 32'h0000_0077, 1'b1, 1'b1, 32'hFFFF_FFFC, 4'hF, 8'd6}   // R6
   };

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int          n;
      int          t0;
      int          exp_n;
      vec_t        v;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R2: reset state
      check(bus_req == 1'b0,    2, "bus_req after reset",    32'(bus_req), 32'h0);
      check(host_ready == 1'b0, 2, "host_ready after reset", 32'(host_ready), 32'h0);
      for (int r = 0; r < 6; r++) begin
         if (r == 2 || r == 3) continue;
         run_op(1'b0, 3'(r), 32'h0, 0, rd, n);
         check(rd == 32'h0, 2, "register zero after reset", rd, 32'h0);
      end

      for (int i = 0; i < NV; i++) begin
         v  = VECS[i];
         t0 = txn_cnt;
         run_op(v.wr, v.rg, v.wd, int'(v.lat), rd, n);
         exp_n = v.bus ? int'(v.lat) + 3 : 1;   // R9 completion latency
         check(n == exp_n, int'(v.rq), "ready latency", 32'(n), 32'(exp_n));
         if (v.chk_rd) check(rd == v.exp_rd, int'(v.rq), "read data", rd, v.exp_rd);
         if (v.bus) begin
            check(txn_cnt == t0 + 1, int'(v.rq), "one bus transfer", 32'(txn_cnt - t0), 32'h1);
            check(last_addr == v.baddr, int'(v.rq), "bus address", last_addr, v.baddr);
            check(last_be == v.be, int'(v.rq), "byte enables", 32'(last_be), 32'(v.be));
            check(last_space == v.rg[2], int'(v.rq), "bus space", 32'(last_space), 32'(v.rg[2]));
            check(last_we == v.wr, int'(v.rq), "bus direction", 32'(last_we), 32'(v.wr));
            if (v.wr) check(last_wdata == v.wd, int'(v.rq), "bus write data", last_wdata, v.wd);
         end else begin
            check(txn_cnt == t0, int'(v.rq), "no bus transfer", 32'(txn_cnt - t0), 32'h0);
         end
      end

      // R11: address held steady for the whole request
      check(stab_err == 0, 11, "address changes during request", 32'(stab_err), 32'h0);

      // R2: reset again mid-run clears pointers and address words
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(host_ready == 1'b0 && bus_req == 1'b0, 2, "outputs in reset",
            {30'h0, host_ready, bus_req}, 32'h0);
      rst_n = 1'b1;
      run_op(1'b0, 3'd0, 32'h0, 0, rd, n);
      check(rd == 32'h0, 2, "read pointer after second reset", rd, 32'h0);
      run_op(1'b0, 3'd4, 32'h0, 0, rd, n);
      check(rd == 32'h0, 2, "peripheral word after second reset", rd, 32'h0);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule